// File: doc/BRIEF.md
# GPIO Bank with Interrupt Detection

This block is one 32-pin general-purpose I/O bank that software controls through a small word-addressed register bus. Seven state registers configure each pin: output data, interrupt mask, pull-up disable, function enable, select, direction and trigger. Each of these registers has a readable base word plus two write-only alias words. Writing the set alias ORs the written ones into the register. Writing the clear alias removes them. Because of this, software can change one pin without a read-modify-write.

A pin's mode comes from its function and select bits. With function=0 and select=0 the pin is a plain GPIO whose output enable follows the direction bit. With function=1 the pin hands over to one of three alternate functions, reported on `alt_sel`. With function=0 and select=1 the pin is an interrupt source. In that mode the direction bit gives the polarity and the trigger bit chooses between edge and level detection. Detected events latch into a per-pin flag. One combined interrupt output and the index of the highest flagged pin go to the system interrupt controller.

The bus is a plain request port. A write takes effect at the clock edge on which `reg_sel` and `reg_wr` are high. A read returns its data one cycle after the request, marked by `rd_vld`. There is no back-pressure: every request is accepted in its own cycle.

Top module: `gpio_irq_bank`

## Requirements
- R1: Word address = group*4 + access. The groups are 0 pin level, 1 data, 2 mask, 3 pull, 4 function, 5 select, 6 direction, 7 trigger, 8 flag. The access codes are 0 base, 1 set, 2 clear. A base write to groups 1..7 loads the whole register. Set ORs in the written ones. Clear removes them. Zero bits are left unchanged.
- R2: After reset all registers read 0, except mask, which reads all ones.
- R3: A read returns data on `reg_rdata` with `rd_vld` high exactly one cycle after the request. Reads of the set or clear aliases, of access code 3 and of unused groups return 0. Writes to the flag base or flag set alias have no effect.
- R4: A read of group 0 returns the pin inputs after a two-flop synchronizer. A pin change is visible from the second clock edge after it.
- R5: `pad_oe` bit i is 1 only when pin i has function=0, select=0 and direction=1. `pad_out` always carries the data register.
- R6: `alt_sel` field i (bits 2i+1:2i) is 0 for function=0. With function=1 it is 1 when select=0, 2 when select=1 and trigger=0, and 3 when select=1 and trigger=1.
- R7: `pull_off` equals the pull register. A 1 disables the pull-up.
- R8: In interrupt mode with trigger=1, direction=1 flags a rising edge and direction=0 flags a falling edge. Each qualifying edge sets the flag once; the opposite edge does nothing.
- R9: `irq_out` is high exactly when some flag bit is set whose mask bit is 0.
- R10: `irq_pin` is the index of the highest-numbered set flag bit, whether masked or not.
- R11: Flags are only set for pins in interrupt mode (function=0, select=1). Pins in GPIO or alternate mode never set a flag.
- R12: Writing ones to the flag clear alias (word 0x22) clears those flag bits. Otherwise a flag stays set.
- R13: In interrupt mode with trigger=0, direction=1 flags while the pin is high and direction=0 flags while it is low. When an event and a clear of the same pin fall in one cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | Bus request |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 6 | Word address: group in bits 5:2, access in bits 1:0 |
| reg_wdata | input | 32 | Write data, one bit per pin |
| reg_rdata | output | 32 | Read data |
| rd_vld | output | 1 | Read data valid, one cycle after a read request |
| pad_in | input | 32 | Pin input levels (asynchronous) |
| pad_out | output | 32 | Output data to pads |
| pad_oe | output | 32 | Output enable to pads |
| pull_off | output | 32 | Pull-up disable per pin |
| alt_sel | output | 64 | Alternate-function code per pin, 2 bits each |
| irq_out | output | 1 | Combined interrupt request |
| irq_pin | output | 5 | Highest flagged pin index |

## Verification
A wrong bit in one of the seven state registers shows up on `pad_oe`, `pull_off` or `alt_sel` at the first falling edge after the write. It also shows up on the next read of that group. A fault in synchronisation or detection appears as a flag read that is wrong three clock edges after a pin change. It also appears as `irq_out` and `irq_pin` disagreeing with the flag and mask values read back. The bench drives edges and levels in both polarities. It clears flags while a level is still active, so that a flag which re-sets, sticks or disappears is seen on the next read.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  // register groups (word address bits 5:2)
  localparam logic [3:0] GRP_LEVEL = 4'd0;
  localparam logic [3:0] GRP_DATA  = 4'd1;
  localparam logic [3:0] GRP_MASK  = 4'd2;
  localparam logic [3:0] GRP_PULL  = 4'd3;
  localparam logic [3:0] GRP_FUNC  = 4'd4;
  localparam logic [3:0] GRP_SEL   = 4'd5;
  localparam logic [3:0] GRP_DIR   = 4'd6;
  localparam logic [3:0] GRP_TRIG  = 4'd7;
  localparam logic [3:0] GRP_FLAG  = 4'd8;

  typedef enum logic [1:0] {
    ACC_BASE = 2'd0,
    ACC_SET  = 2'd1,
    ACC_CLR  = 2'd2,
    ACC_RSVD = 2'd3
  } acc_e;

  localparam int unsigned FIRST_STATE = 1;
  localparam int unsigned LAST_STATE  = 7;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] level_q,
  output logic [WIDTH-1:0] prev_q
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= '0;
      level_q <= '0;
      prev_q  <= '0;
    end else begin
      meta_q  <= async_in;
      level_q <= meta_q;
      prev_q  <= level_q;
    end
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int unsigned PINS = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] level,
  input  logic [PINS-1:0] prev,
  input  logic [PINS-1:0] irq_en,
  input  logic [PINS-1:0] edge_mode,
  input  logic [PINS-1:0] active_high,
  input  logic [PINS-1:0] clr_bits,
  output logic [PINS-1:0] flag_q
);
  for (genvar i = 0; i < PINS; i++) begin : g_pin
    logic hit;
    always_comb begin
      if (edge_mode[i])
        hit = active_high[i] ? (level[i] & ~prev[i]) : (~level[i] & prev[i]);
      else
        hit = active_high[i] ? level[i] : ~level[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        flag_q[i] <= 1'b0;
      else if (irq_en[i] && hit)
        flag_q[i] <= 1'b1;
      else if (clr_bits[i])
        flag_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/gpio_hi_prio.sv
module gpio_hi_prio #(
  parameter int unsigned PINS  = 32,
  parameter int unsigned IDX_W = $clog2(PINS)
) (
  input  logic [PINS-1:0]  req,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < PINS; i++)
      if (req[i]) idx = IDX_W'(i);
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned N_PINS = 32,
  parameter int unsigned ADDR_W = 6,
  localparam int unsigned IDX_W = $clog2(N_PINS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_sel,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [N_PINS-1:0]   reg_wdata,
  output logic [N_PINS-1:0]   reg_rdata,
  output logic                rd_vld,
  input  logic [N_PINS-1:0]   pad_in,
  output logic [N_PINS-1:0]   pad_out,
  output logic [N_PINS-1:0]   pad_oe,
  output logic [N_PINS-1:0]   pull_off,
  output logic [2*N_PINS-1:0] alt_sel,
  output logic                irq_out,
  output logic [IDX_W-1:0]    irq_pin
);
  logic [3:0] grp;
  acc_e       acc;
  logic       wr_en;
  assign grp   = reg_addr[5:2];
  assign acc   = acc_e'(reg_addr[1:0]);
  assign wr_en = reg_sel & reg_wr;

  // state registers, one per group 1..7
  logic [N_PINS-1:0] st_q [FIRST_STATE:LAST_STATE];

  for (genvar r = FIRST_STATE; r <= LAST_STATE; r++) begin : g_state
    localparam logic [N_PINS-1:0] RST_VAL = (r == int'(GRP_MASK)) ? '1 : '0;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        st_q[r] <= RST_VAL;
      else if (wr_en && grp == 4'(r)) begin
        case (acc)
          ACC_BASE: st_q[r] <= reg_wdata;
          ACC_SET:  st_q[r] <= st_q[r] | reg_wdata;
          ACC_CLR:  st_q[r] <= st_q[r] & ~reg_wdata;
          default:  st_q[r] <= st_q[r];
        endcase
      end
    end
  end

  logic [N_PINS-1:0] data_q, mask_q, pull_q, func_q, sel_q, dir_q, trig_q;
  assign data_q = st_q[1];
  assign mask_q = st_q[2];
  assign pull_q = st_q[3];
  assign func_q = st_q[4];
  assign sel_q  = st_q[5];
  assign dir_q  = st_q[6];
  assign trig_q = st_q[7];

  // input sampling
  logic [N_PINS-1:0] level_q, prev_q;
  gpio_in_sync #(.WIDTH(N_PINS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pad_in),
    .level_q  (level_q),
    .prev_q   (prev_q)
  );

  // interrupt detection
  logic [N_PINS-1:0] irq_mode, flag_clr, flag_q;
  assign irq_mode = ~func_q & sel_q;
  assign flag_clr = (wr_en && grp == GRP_FLAG && acc == ACC_CLR) ? reg_wdata : '0;

  gpio_irq_detect #(.PINS(N_PINS)) u_detect (
    .clk         (clk),
    .rst_n       (rst_n),
    .level       (level_q),
    .prev        (prev_q),
    .irq_en      (irq_mode),
    .edge_mode   (trig_q),
    .active_high (dir_q),
    .clr_bits    (flag_clr),
    .flag_q      (flag_q)
  );

  gpio_hi_prio #(.PINS(N_PINS), .IDX_W(IDX_W)) u_prio (
    .req (flag_q),
    .idx (irq_pin)
  );

  assign irq_out = |(flag_q & ~mask_q);

  // pad side
  assign pad_out  = data_q;
  assign pad_oe   = ~func_q & ~sel_q & dir_q;
  assign pull_off = pull_q;

  for (genvar i = 0; i < N_PINS; i++) begin : g_alt
    always_comb begin
      if (!func_q[i])     alt_sel[2*i +: 2] = 2'd0;
      else if (!sel_q[i]) alt_sel[2*i +: 2] = 2'd1;
      else if (!trig_q[i]) alt_sel[2*i +: 2] = 2'd2;
      else                alt_sel[2*i +: 2] = 2'd3;
    end
  end

  // read path, one cycle latency
  logic [N_PINS-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (acc == ACC_BASE) begin
      case (grp)
        GRP_LEVEL: rd_mux = level_q;
        GRP_DATA:  rd_mux = data_q;
        GRP_MASK:  rd_mux = mask_q;
        GRP_PULL:  rd_mux = pull_q;
        GRP_FUNC:  rd_mux = func_q;
        GRP_SEL:   rd_mux = sel_q;
        GRP_DIR:   rd_mux = dir_q;
        GRP_TRIG:  rd_mux = trig_q;
        GRP_FLAG:  rd_mux = flag_q;
        default:   rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld    <= 1'b0;
      reg_rdata <= '0;
    end else begin
      rd_vld    <= reg_sel & ~reg_wr;
      reg_rdata <= (reg_sel & ~reg_wr) ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int unsigned N_PINS = 32,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned IDX_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_sel,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [N_PINS-1:0] reg_wdata,
  input logic              rd_vld,
  input logic [N_PINS-1:0] pad_oe,
  input logic              irq_out,
  input logic [IDX_W-1:0]  irq_pin,
  input logic [N_PINS-1:0] flag_q,
  input logic [N_PINS-1:0] mask_q,
  input logic [N_PINS-1:0] func_q,
  input logic [N_PINS-1:0] sel_q,
  input logic [N_PINS-1:0] dir_q
);
  logic [N_PINS-1:0] bus_clr;
  assign bus_clr = (reg_sel && reg_wr && reg_addr == ADDR_W'(6'h22)) ? reg_wdata : '0;

  assert_oe_gpio_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & (func_q | sel_q | ~dir_q)) == '0);

  assert_flag_in_irq_mode_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q & ~$past(flag_q)) & ~$past(~func_q & sel_q)) == '0);

  assert_flag_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flag_q) & ~flag_q & ~$past(bus_clr)) == '0);

  assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> ((flag_q & ~mask_q) != '0));

  assert_pin_is_flagged_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q != '0) |-> flag_q[irq_pin]);

  assert_read_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && !reg_wr) |=> rd_vld);
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(
  .N_PINS (N_PINS),
  .ADDR_W (ADDR_W),
  .IDX_W  (IDX_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_sel   (reg_sel),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .rd_vld    (rd_vld),
  .pad_oe    (pad_oe),
  .irq_out   (irq_out),
  .irq_pin   (irq_pin),
  .flag_q    (flag_q),
  .mask_q    (mask_q),
  .func_q    (func_q),
  .sel_q     (sel_q),
  .dir_q     (dir_q)
);

// File: tb/gpio_irq_bank_bench.sv
module gpio_irq_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        rd_vld;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe, pull_off;
  logic [63:0] alt_sel;
  logic        irq_out;
  logic [4:0]  irq_pin;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;

  gpio_irq_bank u_gpio_irq_bank (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rd_vld(rd_vld), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pull_off(pull_off), .alt_sel(alt_sel), .irq_out(irq_out), .irq_pin(irq_pin)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pop expected read data when the design returns it
  always @(negedge clk) begin
    if (rst_n && rd_vld) begin
      if (exp_q.size() == 0) begin
        check("R3 unexpected rd_vld", 64'(rd_vld), 64'd0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, 64'(reg_rdata), 64'(e));
      end
    end
  end

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, logic [31:0] e, string tag);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    reg_sel = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);

    // reset state
    rd(6'h08, 32'hFFFF_FFFF, "R2 mask reset");
    rd(6'h04, 32'h0, "R2 data reset");
    rd(6'h20, 32'h0, "R2 flag reset");
    check("R2 irq_out reset", 64'(irq_out), 64'd0);
    check("R2 pad_oe reset", 64'(pad_oe), 64'd0);

    // base / set / clear semantics
    wr(6'h04, 32'h0000_00A5);
    wr(6'h05, 32'h0000_0F00);
    wr(6'h06, 32'h0000_0005);
    rd(6'h04, 32'h0000_0FA0, "R1 data set/clear");
    rd(6'h05, 32'h0, "R3 set alias reads zero");
    rd(6'h07, 32'h0, "R3 reserved access reads zero");

    // GPIO outputs and alternate functions
    wr(6'h19, 32'h0000_007F);   // direction set pins 0..6
    wr(6'h11, 32'h0000_0070);   // function set pins 4..6
    wr(6'h15, 32'h0000_0060);   // select set pins 5,6
    wr(6'h1D, 32'h0000_0040);   // trigger set pin 6
    check("R5 pad_oe gpio only", 64'(pad_oe), 64'h0F);
    check("R5 pad_out data", 64'(pad_out), 64'h0FA0);
    check("R6 alt_sel codes", alt_sel, 64'h3900);
    wr(6'h0D, 32'h0000_0008);
    check("R7 pull_off", 64'(pull_off), 64'h8);

    // pin levels, gpio pins never flag
    pad_in = 32'h0000_0005;
    wait_cyc(4);
    rd(6'h00, 32'h0000_0005, "R4 level read");
    rd(6'h20, 32'h0, "R11 gpio pin no flag");
    pad_in = 32'h0;
    wait_cyc(4);

    // rising edge, pin 8
    wr(6'h1D, 32'h100); wr(6'h19, 32'h100); wr(6'h15, 32'h100); wr(6'h0A, 32'h100);
    check("R9 no irq before edge", 64'(irq_out), 64'd0);
    pad_in[8] = 1'b1;
    wait_cyc(4);
    rd(6'h20, 32'h100, "R8 rising flag");
    check("R9 irq_out unmasked", 64'(irq_out), 64'd1);
    check("R10 irq_pin 8", 64'(irq_pin), 64'd8);
    wr(6'h22, 32'h100);
    wait_cyc(2);
    rd(6'h20, 32'h0, "R12 clear, edge once");
    pad_in[8] = 1'b0;
    wait_cyc(4);
    rd(6'h20, 32'h0, "R8 falling ignored on rising pin");

    // falling edge, pin 9
    wr(6'h1D, 32'h200); wr(6'h15, 32'h200);
    pad_in[9] = 1'b1;
    wait_cyc(4);
    rd(6'h20, 32'h0, "R8 rising ignored on falling pin");
    pad_in[9] = 1'b0;
    wait_cyc(4);
    rd(6'h20, 32'h200, "R8 falling flag");
    wr(6'h22, 32'h200);

    // high level, pin 10
    wr(6'h19, 32'h400); wr(6'h15, 32'h400);
    rd(6'h20, 32'h0, "R13 high level idle");
    pad_in[10] = 1'b1;
    wait_cyc(4);
    wr(6'h22, 32'h400);
    rd(6'h20, 32'h400, "R13 level wins over clear");
    pad_in[10] = 1'b0;
    wait_cyc(4);
    wr(6'h22, 32'h400);
    rd(6'h20, 32'h0, "R13 high level released");

    // low level, pin 11
    wr(6'h15, 32'h800);
    wait_cyc(2);
    rd(6'h20, 32'h800, "R13 low level flag");
    pad_in[11] = 1'b1;
    wait_cyc(4);
    wr(6'h22, 32'h800);
    rd(6'h20, 32'h0, "R13 low level released");

    // masked rising, pin 12
    wr(6'h1D, 32'h1000); wr(6'h19, 32'h1000); wr(6'h15, 32'h1000);
    pad_in[12] = 1'b1;
    wait_cyc(4);
    rd(6'h20, 32'h1000, "R8 masked pin still flags");
    check("R9 masked no irq", 64'(irq_out), 64'd0);
    check("R10 irq_pin masked 12", 64'(irq_pin), 64'd12);

    // two flags, highest wins
    pad_in[8] = 1'b1;
    wait_cyc(4);
    rd(6'h20, 32'h1100, "R8 second flag");
    check("R9 irq with pin 8", 64'(irq_out), 64'd1);
    check("R10 highest is 12", 64'(irq_pin), 64'd12);

    // flag base / set writes ignored
    wr(6'h20, 32'hFFFF_FFFF);
    wr(6'h21, 32'hFFFF_FFFF);
    rd(6'h20, 32'h1100, "R3 flag base/set write ignored");

    wr(6'h22, 32'hFFFF_FFFF);
    rd(6'h20, 32'h0, "R12 clear all");
    check("R9 irq low after clear", 64'(irq_out), 64'd0);

    wait_cyc(3);
    check("R3 read queue drained", 64'(exp_q.size()), 64'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule